// File: doc/BRIEF.md
# Converter Bus Control Decoder

This block is the processor-side control logic of a 12-bit successive-approximation converter. It watches the chip-enable, active-low chip-select, read/convert, word-width strap and address inputs. From them it decides whether to start a full-length conversion, start a short conversion, or put the result on the data bus. The conversion engine is outside the block. The engine takes a one-cycle start pulse and a held length bit, and it returns a busy flag and a 12-bit result.

A convert command is taken only at the moment the device becomes selected, and only when read/convert is already low at that moment. Holding the device selected therefore produces a single start. While a conversion is pending or running, the status output is high. During that time further starts are dropped and the output drivers stay off.

Reads either drive the whole 12-bit word or drive one left-justified byte on the upper eight lines. With the strap high, all 12 bits go out at once. With the strap low, the address bit selects the eight MSBs, or the four LSBs followed by four zero bits. Each 4-bit nibble of the bus has its own output-enable, which the bus wrapper uses to drive tri-state buffers.

Top module: `cvt_bus_ctrl`

## Requirements
- R1: While ce_i is 0 or cs_ni is 1, start_o stays 0 and data_oe_o is 000 with data_o 0 on the following cycle.
- R2: When the device becomes selected (ce_i=1, cs_ni=0 where the previous cycle was unselected) with rd_cvt_i=0, busy_i=0 and addr_i=0, start_o is 1 for the next cycle and short_o is 0 from then on.
- R3: The same start with addr_i=1 gives short_o=1; short_o holds the captured value until the next accepted start.
- R4: A convert selection held for several cycles gives exactly one start_o pulse.
- R5: If rd_cvt_i is 1 in the cycle the device becomes selected, no start follows, even if rd_cvt_i drops while the selection is held.
- R6: A read (selected, rd_cvt_i=1, sts_o=0) with wide_i=1 gives data_oe_o=111 and data_o equal to result_i on the next cycle.
- R7: A read with wide_i=0 and addr_i=0 gives data_oe_o=110, data_o[11:4]=result_i[11:4] and data_o[3:0]=0.
- R8: A read with wide_i=0 and addr_i=1 gives data_oe_o=110, data_o[11:8]=result_i[3:0] and data_o[7:0]=0.
- R9: While sts_o is 1, a read leaves data_oe_o at 000 and data_o at 0 on the next cycle.
- R10: While busy_i is 1, a selection edge with a convert command produces no start.
- R11: sts_o equals busy_i OR start_o in the same cycle, with no added delay.
- R12: After reset, start_o, short_o, data_oe_o and data_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Chip enable, active high |
| cs_ni | input | 1 | Chip select, active low |
| rd_cvt_i | input | 1 | 1 = read, 0 = convert |
| wide_i | input | 1 | Width strap: 1 = 12-bit word, 0 = two bytes |
| addr_i | input | 1 | Short-conversion select on convert; byte select on read |
| busy_i | input | 1 | Conversion engine busy |
| result_i | input | 12 | Conversion engine result |
| start_o | output | 1 | One-cycle start pulse to the engine |
| short_o | output | 1 | Length of the latest start, 1 = 8-bit |
| sts_o | output | 1 | Status: conversion pending or running |
| data_o | output | 12 | Formatted data bus value |
| data_oe_o | output | 3 | Per-nibble output enable, bit n for data_o[4n+3:4n] |

## Verification
start_o, short_o, data_o and data_oe_o each come from one register. They are therefore due one clock after the inputs that cause them. sts_o is combinational and is due in the same cycle. The bench drives its inputs one time unit after a rising edge. It checks sts_o shortly after driving, before the next edge. It checks the registered outputs one time unit after that edge, against a model that keeps its own copy of the previous selection and of the pending start pulse.

// File: rtl/cvt_pkg.sv
package cvt_pkg;
  typedef enum logic [1:0] {
    RD_OFF  = 2'd0,
    RD_WORD = 2'd1,
    RD_HI   = 2'd2,
    RD_LO   = 2'd3
  } rd_fmt_e;
endpackage

// File: rtl/cvt_cmd_decode.sv
module cvt_cmd_decode
  import cvt_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    ce_i,
  input  logic    cs_ni,
  input  logic    rd_cvt_i,
  input  logic    wide_i,
  input  logic    addr_i,
  input  logic    busy_i,
  output logic    start_o,
  output logic    short_o,
  output logic    sts_o,
  output rd_fmt_e fmt_o
);
  logic sel, sel_q, start_d, start_q, short_q;

  assign sel = ce_i & ~cs_ni;
  // start only on the selection edge with convert already requested
  assign start_d = sel & ~sel_q & ~rd_cvt_i & ~busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= 1'b0;
      start_q <= 1'b0;
      short_q <= 1'b0;
    end else begin
      sel_q   <= sel;
      start_q <= start_d;
      if (start_d) short_q <= addr_i;
    end
  end

  assign start_o = start_q;
  assign short_o = short_q;
  assign sts_o   = busy_i | start_q;

  always_comb begin
    fmt_o = RD_OFF;
    if (sel && rd_cvt_i && !sts_o) begin
      if (wide_i)      fmt_o = RD_WORD;
      else if (addr_i) fmt_o = RD_LO;
      else             fmt_o = RD_HI;
    end
  end

  AST_IDLE_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ce_i && !cs_ni) |=> !start_o); // R1
  AST_ONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o); // R4
  AST_LEN_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> short_o == $past(addr_i)); // R3
  AST_BUSY_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !start_o); // R10
  AST_BUSY_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> fmt_o == RD_OFF); // R9
endmodule

// File: rtl/cvt_out_fmt.sv
module cvt_out_fmt
  import cvt_pkg::*;
#(
  parameter int NIB_W   = 4,
  parameter int NIBBLES = 3,
  localparam int DATA_W    = NIB_W * NIBBLES,
  localparam int BYTE_NIBS = 2,
  localparam int BYTE_W    = NIB_W * BYTE_NIBS,
  localparam int LO_W      = DATA_W - BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  rd_fmt_e           fmt_i,
  input  logic [DATA_W-1:0] result_i,
  output logic [DATA_W-1:0] data_o,
  output logic [NIBBLES-1:0] oe_o
);
  logic [DATA_W-1:0]  word;
  logic [DATA_W-1:0]  data_d;
  logic [NIBBLES-1:0] oe_d;

  // low byte: LSBs left-justified, trailing zeros
  always_comb begin
    case (fmt_i)
      RD_LO:   word = result_i << BYTE_W;
      default: word = result_i;
    endcase
  end

  for (genvar n = 0; n < NIBBLES; n++) begin : g_nib
    localparam bit IN_BYTE = (n >= NIBBLES - BYTE_NIBS);
    assign oe_d[n] = (fmt_i == RD_WORD) ||
                     (IN_BYTE && (fmt_i == RD_HI || fmt_i == RD_LO));
    assign data_d[n*NIB_W +: NIB_W] = oe_d[n] ? word[n*NIB_W +: NIB_W] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      oe_o   <= '0;
    end else begin
      data_o <= data_d;
      oe_o   <= oe_d;
    end
  end

  AST_WORD_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fmt_i == RD_WORD |=> (oe_o == '1) && (data_o == $past(result_i))); // R6
  AST_LO_PAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fmt_i == RD_LO |=> data_o[DATA_W-LO_W-1:0] == '0); // R8
  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fmt_i == RD_OFF |=> (oe_o == '0) && (data_o == '0)); // R1
endmodule

// File: rtl/cvt_bus_ctrl.sv
module cvt_bus_ctrl
  import cvt_pkg::*;
#(
  parameter int NIB_W   = 4,
  parameter int NIBBLES = 3,
  localparam int DATA_W = NIB_W * NIBBLES
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ce_i,
  input  logic               cs_ni,
  input  logic               rd_cvt_i,
  input  logic               wide_i,
  input  logic               addr_i,
  input  logic               busy_i,
  input  logic [DATA_W-1:0]  result_i,
  output logic               start_o,
  output logic               short_o,
  output logic               sts_o,
  output logic [DATA_W-1:0]  data_o,
  output logic [NIBBLES-1:0] data_oe_o
);
  rd_fmt_e fmt;

  cvt_cmd_decode i_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ce_i     (ce_i),
    .cs_ni    (cs_ni),
    .rd_cvt_i (rd_cvt_i),
    .wide_i   (wide_i),
    .addr_i   (addr_i),
    .busy_i   (busy_i),
    .start_o  (start_o),
    .short_o  (short_o),
    .sts_o    (sts_o),
    .fmt_o    (fmt)
  );

  cvt_out_fmt #(.NIB_W(NIB_W), .NIBBLES(NIBBLES)) i_fmt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fmt_i    (fmt),
    .result_i (result_i),
    .data_o   (data_o),
    .oe_o     (data_oe_o)
  );

  AST_STS_BLOCKS_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_o |=> data_oe_o == '0); // R9
endmodule

// File: tb/test_cvt_bus_ctrl.sv
module test_cvt_bus_ctrl;
  logic clk = 0, rst_n = 0;
  logic ce = 0, cs_n = 1, rd = 0, wide = 0, addr = 0, busy = 0;
  logic [11:0] res = '0;
  logic start, short_l, sts;
  logic [11:0] data;
  logic [2:0] oe;
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic m_sel_prev = 0, m_start = 0, m_short = 0;

  always #10 clk = ~clk;

  cvt_bus_ctrl i_cvt_bus_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .cs_ni(cs_n), .rd_cvt_i(rd),
    .wide_i(wide), .addr_i(addr), .busy_i(busy), .result_i(res),
    .start_o(start), .short_o(short_l), .sts_o(sts), .data_o(data),
    .data_oe_o(oe)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [11:0] exp_data(logic w, logic a, logic [11:0] r);
    if (w)      return r;
    else if (a) return {r[3:0], 8'h00};
    else        return {r[11:4], 4'h0};
  endfunction

  // drive one cycle of inputs, check sts now and registered outputs after the edge
  task automatic cyc(logic c, logic s, logic r, logic w, logic a, logic b, logic [11:0] v);
    logic sel, e_start, sts_now, rd_ok;
    logic [2:0] e_oe;
    logic [11:0] e_data;
    string ts, td;
    ce = c; cs_n = s; rd = r; wide = w; addr = a; busy = b; res = v;
    sel     = c & ~s;
    sts_now = b | m_start;
    e_start = sel & ~m_sel_prev & ~r & ~b;
    rd_ok   = sel & r & ~sts_now;
    e_oe    = rd_ok ? (w ? 3'b111 : 3'b110) : 3'b000;
    e_data  = rd_ok ? exp_data(w, a, v) : 12'h000;
    if (!sel)                          ts = "R1";
    else if (!r && !m_sel_prev && b)   ts = "R10";
    else if (!r && !m_sel_prev)        ts = a ? "R3" : "R2";
    else if (!r && m_start)            ts = "R4";
    else                               ts = "R5";
    if (!sel)              td = "R1";
    else if (r && sts_now) td = "R9";
    else if (r)            td = w ? "R6" : (a ? "R8" : "R7");
    else                   td = "R2";
    #2;
    chk("R11", "sts_o", sts, sts_now);
    @(posedge clk); #1;
    m_start = e_start;
    if (e_start) m_short = a;
    m_sel_prev = sel;
    chk(ts, "start_o", start, m_start);
    chk(ts, "short_o", short_l, m_short);
    chk(td, "data_oe_o", oe, e_oe);
    chk(td, "data_o", data, e_data);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(posedge clk);
    #1;
    chk("R12", "start_o", start, 0);
    chk("R12", "short_o", short_l, 0);
    chk("R12", "data_oe_o", oe, 0);
    chk("R12", "data_o", data, 0);
    rst_n = 1;
    @(posedge clk); #1;
    // R1: enable low / select high, with command bits set
    cyc(0, 0, 0, 1, 0, 0, 12'hABC);
    cyc(1, 1, 1, 1, 0, 0, 12'hABC);
    cyc(0, 1, 0, 0, 1, 0, 12'hABC);
    // R2 then R4: held convert selection, single pulse
    cyc(1, 0, 0, 0, 0, 0, 12'h123);
    cyc(1, 0, 0, 0, 1, 0, 12'h123);
    cyc(1, 0, 0, 0, 1, 0, 12'h123);
    cyc(0, 1, 0, 0, 0, 0, 12'h123);
    // R3: short start
    cyc(1, 0, 0, 0, 1, 0, 12'h000);
    cyc(1, 0, 1, 1, 0, 0, 12'h5A5); // R9: read right after start blocked
    cyc(0, 1, 0, 0, 0, 1, 12'h000);
    // R10: edge while busy
    cyc(1, 0, 0, 0, 0, 1, 12'h000);
    cyc(0, 1, 0, 0, 0, 0, 12'h000);
    // R5: selected as read, then drop to convert while held
    cyc(1, 0, 1, 1, 0, 0, 12'hF0F);
    cyc(1, 0, 0, 1, 0, 0, 12'hF0F);
    cyc(0, 1, 0, 0, 0, 0, 12'hF0F);
    // R6, R7, R8 reads
    cyc(1, 0, 1, 1, 0, 0, 12'hDEF);
    cyc(1, 0, 1, 0, 0, 0, 12'hDEF);
    cyc(1, 0, 1, 0, 1, 0, 12'hDEF);
    cyc(1, 0, 1, 0, 1, 1, 12'hDEF); // R9 busy
    cyc(0, 1, 0, 0, 0, 0, 12'h000);
    for (int i = 0; i < 4000; i++) begin
      cyc($urandom_range(0, 3) != 0, $urandom_range(0, 3) == 0,
          $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
          $urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0,
          12'($urandom));
    end
    finish_run();
  end
endmodule